// File: doc/BRIEF.md
# Receive FIFO with Flow-Control Watermarks

This block is the receive-side byte queue of a serial port. The deserializer pushes bytes into a 64-entry store. The CPU pops them in arrival order. The block reports the current fill level and compares that level against two programmable watermarks. The lower watermark raises a sticky data-ready flag. The upper watermark raises the request-to-send line, which tells the far end to stop sending.

A 16-bit control word selects both watermarks and holds three more bits. A receive-clear bit empties the queue and holds it empty. A transmit-clear bit is passed on to the transmit FIFO. A loopback bit routes the local transmit serial stream into the receive serial path and forces the request-to-send line high. The CPU can read and write the control word on any cycle.

Top module: `rx_fifo_flowctl`

## Requirements
- R1: After a synchronous reset, the control word reads 0, count is 0, ready is 0, rts is 0, overrun is 0 and pop_data is 0.
- R2: Control word layout: bits 1:0 select the ready watermark, bit 2 is receive clear, bit 3 is transmit clear (driven on tx_fifo_clear), bit 4 is loopback, and bits 10:8 select the rts watermark. Bits 15:11 and 7:5 read 0 and ignore writes. A write is visible on ctrl_rdata from the next cycle.
- R3: Bytes come out in the order they were pushed. The byte requested by a pop appears on pop_data in the cycle after the pop, and pop_data holds its value when no pop is made.
- R4: count runs from 0 to 64 and is updated in the cycle after a push or pop. A push and a pop in the same cycle leave it unchanged.
- R5: A push while count is 64 is dropped, even if a pop is made in the same cycle. Such a push raises overrun for exactly one cycle.
- R6: A pop while count is 0 puts 0 on pop_data and leaves count at 0.
- R7: While receive clear is 1, count reads 0, the stored bytes are discarded, pushes are ignored and pops return 0. The queue stays empty until software writes the bit back to 0.
- R8: Ready watermark codes are 00→1, 01→16, 10→32 and 11→48. ready becomes 1 in the cycle after count is equal to or greater than the selected watermark.
- R9: ready stays 1 until a flag_ack pulse arrives while count is below the watermark. An ack made while count is still at or above the watermark has no effect.
- R10: Rts watermark codes are 000→63, 001→1, 010→8, 011→16, 100→32, 101→48, 110→54 and 111→60. rts is 1 in the cycle after count is strictly greater than the selected watermark, and 0 otherwise.
- R11: With loopback at 1, rx_serial_out follows tx_serial_in and rts is forced to 1 from the next cycle. With loopback at 0, rx_serial_out follows rx_pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write value |
| ctrl_rdata | output | 16 | Control word read value |
| push | input | 1 | Store push_data this cycle |
| push_data | input | 8 | Byte from the deserializer |
| pop | input | 1 | Remove the oldest byte |
| pop_data | output | 8 | Byte removed by the previous pop |
| count | output | 7 | Stored byte count, 0 to 64 |
| overrun | output | 1 | One-cycle pulse on a dropped push |
| flag_ack | input | 1 | Software clear of the ready flag |
| ready | output | 1 | Sticky receive-data-ready flag |
| rts | output | 1 | Flow-control request, high means stop |
| tx_fifo_clear | output | 1 | Transmit FIFO clear bit |
| tx_serial_in | input | 1 | Local transmit serial stream |
| rx_pin | input | 1 | External receive serial line |
| rx_serial_out | output | 1 | Serial stream to the deserializer |

## Verification
Push and pop often fall in the same cycle. This matters most at the empty and full edges, where one of them must win: an empty pop returns zero while its push is still stored, and a full push is dropped while its pop still drains a byte. Random phases with biased push and pop rates drive the queue to both edges many times. Each cycle, a queue model in the bench predicts count, pop_data, overrun and both watermark outputs. Control writes that set receive clear land in the same cycles as pushes, to show that a push made in the write cycle is still stored and is then discarded.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic [2:0] rts_sel;
    logic       loopback;
    logic       tx_clr;
    logic       rx_clr;
    logic [1:0] rdy_sel;
  } rxf_ctrl_t;

  localparam int LEVEL_W = 7;

  function automatic logic [LEVEL_W-1:0] rdy_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return LEVEL_W'(1);
      2'd1:    return LEVEL_W'(16);
      2'd2:    return LEVEL_W'(32);
      default: return LEVEL_W'(48);
    endcase
  endfunction

  function automatic logic [LEVEL_W-1:0] rts_level(input logic [2:0] sel);
    case (sel)
      3'd0:    return LEVEL_W'(63);
      3'd1:    return LEVEL_W'(1);
      3'd2:    return LEVEL_W'(8);
      3'd3:    return LEVEL_W'(16);
      3'd4:    return LEVEL_W'(32);
      3'd5:    return LEVEL_W'(48);
      3'd6:    return LEVEL_W'(54);
      default: return LEVEL_W'(60);
    endcase
  endfunction

endpackage

// File: rtl/rxf_ctrl_reg.sv
module rxf_ctrl_reg
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output rxf_ctrl_t   ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (we) begin
      ctrl.rts_sel  <= wdata[10:8];
      ctrl.loopback <= wdata[4];
      ctrl.tx_clr   <= wdata[3];
      ctrl.rx_clr   <= wdata[2];
      ctrl.rdy_sel  <= wdata[1:0];
    end
  end

  assign rdata = {5'b0, ctrl.rts_sel, 3'b0, ctrl.loopback, ctrl.tx_clr,
                  ctrl.rx_clr, ctrl.rdy_sel};

  // R2: a write shows up on the read port one cycle later
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> (rdata[10:8] == $past(wdata[10:8])) && (rdata[4:0] == $past(wdata[4:0])));

endmodule

// File: rtl/rxf_storage.sv
module rxf_storage #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    count,
  output logic             overrun
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !clr && !full;
  assign do_pop  = pop && !clr && !empty;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // Storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (pop) begin
      pop_data <= do_pop ? mem[rd_ptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) overrun <= 1'b0;
    else     overrun <= push && !clr && full;
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_push_grows_r4: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full && !clr) |=> (count == $past(count) + CW'(1)));

  p_full_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (push && full && !clr) |=> (overrun && count <= CW'(DEPTH)));

  p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (pop_data == '0 && count == '0));

  p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

endmodule

// File: rtl/rxf_levels.sv
module rxf_levels
  import rxf_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic [1:0]    rdy_sel,
  input  logic [2:0]    rts_sel,
  input  logic          loopback,
  input  logic          flag_ack,
  output logic          ready,
  output logic          rts
);

  logic at_ready, over_rts;

  assign at_ready = int'(count) >= int'(rdy_level(rdy_sel));
  assign over_rts = int'(count) >  int'(rts_level(rts_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      rts   <= 1'b0;
    end else begin
      ready <= at_ready || (ready && !flag_ack);
      rts   <= loopback || over_rts;
    end
  end

  p_sticky_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (ready && !flag_ack) |=> ready);

  p_rts_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!loopback && int'(count) <= int'(rts_level(rts_sel))) |=> !rts);

  p_loop_rts_r11: assert property (@(posedge clk) disable iff (rst)
    loopback |=> rts);

endmodule

// File: rtl/rx_fifo_flowctl.sv
module rx_fifo_flowctl
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic [15:0]      ctrl_wdata,
  output logic [15:0]      ctrl_rdata,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    count,
  output logic             overrun,
  input  logic             flag_ack,
  output logic             ready,
  output logic             rts,
  output logic             tx_fifo_clear,
  input  logic             tx_serial_in,
  input  logic             rx_pin,
  output logic             rx_serial_out
);

  rxf_ctrl_t ctrl;

  rxf_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctrl_we),
    .wdata (ctrl_wdata),
    .rdata (ctrl_rdata),
    .ctrl  (ctrl)
  );

  rxf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .clr       (ctrl.rx_clr),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .pop_data  (pop_data),
    .count     (count),
    .overrun   (overrun)
  );

  rxf_levels #(.CW(CW)) u_levels (
    .clk      (clk),
    .rst      (rst),
    .count    (count),
    .rdy_sel  (ctrl.rdy_sel),
    .rts_sel  (ctrl.rts_sel),
    .loopback (ctrl.loopback),
    .flag_ack (flag_ack),
    .ready    (ready),
    .rts      (rts)
  );

  assign tx_fifo_clear = ctrl.tx_clr;
  assign rx_serial_out = ctrl.loopback ? tx_serial_in : rx_pin;

endmodule

// File: tb/rx_fifo_flowctl_test.sv
`timescale 1ns/1ps
module rx_fifo_flowctl_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        ctrl_we = 0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        push = 0;
  logic [7:0]  push_data = '0;
  logic        pop = 0;
  logic [7:0]  pop_data;
  logic [6:0]  count;
  logic        overrun, flag_ack = 0, ready, rts, tx_fifo_clear;
  logic        tx_serial_in = 0, rx_pin = 0, rx_serial_out;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_fifo_flowctl uut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .count(count), .overrun(overrun), .flag_ack(flag_ack),
    .ready(ready), .rts(rts), .tx_fifo_clear(tx_fifo_clear),
    .tx_serial_in(tx_serial_in), .rx_pin(rx_pin), .rx_serial_out(rx_serial_out)
  );

  // Model state
  logic [7:0]  m_q[$];
  logic [15:0] m_reg = '0;
  logic [7:0]  e_pd = '0;
  bit          e_ready = 0, e_rts = 0, e_ovr = 0;

  function automatic int rdy_thr(input logic [1:0] s);
    int t[4] = '{1, 16, 32, 48};
    return t[s];
  endfunction

  function automatic int rts_thr(input logic [2:0] s);
    int t[8] = '{63, 1, 8, 16, 32, 48, 54, 60};
    return t[s];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R4 count", int'(count), m_q.size());
    check("R3 pop_data", int'(pop_data), int'(e_pd));
    check("R5 overrun", int'(overrun), int'(e_ovr));
    check("R8 ready", int'(ready), int'(e_ready));
    check("R10 rts", int'(rts), int'(e_rts));
    check("R2 ctrl_rdata", int'(ctrl_rdata), int'(m_reg));
    check("R2 tx_fifo_clear", int'(tx_fifo_clear), int'(m_reg[3]));
  endtask

  // Called at a negative edge; applies one cycle of stimulus and checks
  task automatic cyc(input bit we, input logic [15:0] wd, input bit ps,
                     input logic [7:0] d, input bit pp, input bit ack);
    int old;
    ctrl_we = we; ctrl_wdata = wd; push = ps; push_data = d; pop = pp; flag_ack = ack;
    @(posedge clk);
    old = m_q.size();
    e_ready = (old >= rdy_thr(m_reg[1:0])) || (e_ready && !ack);
    e_rts   = m_reg[4] || (old > rts_thr(m_reg[10:8]));
    e_ovr   = 0;
    if (m_reg[2]) begin
      m_q.delete();
      if (pp) e_pd = '0;
    end else begin
      if (pp) e_pd = (old == 0) ? 8'h00 : m_q.pop_front();
      if (ps) begin
        if (old < 64) m_q.push_back(d);
        else e_ovr = 1;
      end
    end
    if (we) m_reg = wd & 16'h071F;
    @(negedge clk);
    ctrl_we = 0; push = 0; pop = 0; flag_ack = 0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 ctrl_rdata", int'(ctrl_rdata), 0);
    check("R1 count", int'(count), 0);
    check("R1 ready", int'(ready), 0);
    check("R1 rts", int'(rts), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 pop_data", int'(pop_data), 0);

    // R2 reserved bits read 0
    cyc(1, 16'hFFFF, 0, '0, 0, 0);
    check("R2 reserved", int'(ctrl_rdata), 16'h071F);
    cyc(1, 16'h0000, 0, '0, 0, 0);
    idle(2);

    // R5 fill to 64, then push into full (alone and with a pop)
    for (int i = 0; i < 64; i++) cyc(0, '0, 1, 8'(i + 7), 0, 0);
    cyc(0, '0, 1, 8'hEE, 0, 0);
    check("R5 full count", int'(count), 64);
    cyc(0, '0, 1, 8'hDD, 1, 0);
    idle(1);

    // R6 drain fully then pop empty
    for (int i = 0; i < 65; i++) cyc(0, '0, 0, '0, 1, 0);
    cyc(0, '0, 0, '0, 1, 0);
    check("R6 empty pop data", int'(pop_data), 0);
    check("R6 empty pop count", int'(count), 0);
    idle(2);

    // R7 clear: push while the write lands, then pushes while set
    for (int i = 0; i < 5; i++) cyc(0, '0, 1, 8'(i), 0, 0);
    cyc(1, 16'h0004, 1, 8'h55, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, 8'(i), 1, 0);
    check("R7 count while clear", int'(count), 0);
    cyc(1, 16'h0000, 0, '0, 0, 0);
    idle(1);
    check("R7 stays empty", int'(count), 0);

    // R9 ack ignored while count still at watermark
    cyc(0, '0, 1, 8'h11, 0, 0);
    idle(1);
    cyc(0, '0, 0, '0, 0, 1);
    check("R9 ack ignored", int'(ready), 1);
    cyc(0, '0, 0, '0, 1, 0);
    idle(1);
    cyc(0, '0, 0, '0, 0, 1);
    check("R9 ack clears", int'(ready), 0);

    // R11 loopback serial routing and forced rts
    tx_serial_in = 1; rx_pin = 0;
    cyc(1, 16'h0010, 0, '0, 0, 0);
    idle(1);
    #0.1;
    check("R11 loop path", int'(rx_serial_out), 1);
    check("R11 loop rts", int'(rts), 1);
    cyc(1, 16'h0000, 0, '0, 0, 0);
    #0.1;
    check("R11 pin path", int'(rx_serial_out), 0);
    tx_serial_in = 0; rx_pin = 1;
    #0.1;
    check("R11 pin path high", int'(rx_serial_out), 1);

    // Random phases: R3 R4 R5 R8 R10 checked each cycle by the model
    for (int b = 0; b < 40; b++) begin
      int pp_pct, po_pct;
      logic [15:0] w;
      pp_pct = 20 + int'($urandom_range(0, 70));
      po_pct = 20 + int'($urandom_range(0, 70));
      w = 16'($urandom) & 16'h0713;
      if ($urandom_range(0, 7) == 0) w[2] = 1'b1;
      cyc(1, w, 0, '0, 0, 0);
      for (int i = 0; i < 100; i++) begin
        bit wx;
        logic [15:0] w2;
        wx = ($urandom_range(0, 99) < 2);
        w2 = w & ~16'h0004;
        cyc(wx, w2,
            ($urandom_range(0, 99) < pp_pct),
            8'($urandom),
            ($urandom_range(0, 99) < po_pct),
            ($urandom_range(0, 99) < 10));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule